// File: doc/BRIEF.md
# Midpoint Balancing Common-Mode Injector

This block sits between a three-phase reference generator and a carrier-based PWM stage of a three-level clamped inverter. Once per control period, marked by a one-cycle strobe, it takes three signed phase references, one current-sign bit per phase, and the signed voltage difference between the upper and lower DC-link capacitors. It adds one common offset to all three references. The offset shifts on-time between the redundant P-type and N-type small vectors, and that pulls the midpoint back towards zero.

The block needs no angle computation. It finds the phase with the largest reference magnitude and uses that phase's sign to pick one of six sections. The dominant phase's current sign, together with its reference sign, tells whether P-type small vectors push current into the midpoint. That result and the sign of the midpoint error set the polarity of the offset. The size of the offset is the error scaled by a gain and capped. The offset is then trimmed so that the adjusted references keep within the modulation limit.

Top module: `np_zs_balancer`

## Requirements
- R1: While rst_ni is low, all three adjusted outputs read 0 and sect_o reads 0.
- R2: Outputs change only on the clock edge where strobe_i is high. They hold their values in every other cycle, whatever the inputs do.
- R3: The largest reference magnitude selects the dominant phase, and its sign selects sect_o. The codes are: A positive = 0, C negative = 1, B positive = 2, A negative = 3, C positive = 4, B negative = 5. A reference of zero counts as positive.
- R4: The same signed offset is added to all three references.
- R5: When |mp_err_i| <= deadband_i, the offset is zero and each output equals its reference.
- R6: The polarity is set as follows. cur_pos_i bit k (A=0, B=1, C=2) is 1 when that phase current is positive. The dominant phase is "sinking" when its current-sign bit differs from its reference-sign bit. The offset is positive when the sign of mp_err_i matches "sinking": positive error with sinking, or negative error without sinking. It is negative otherwise.
- R7: The offset magnitude is (|mp_err_i| * gain_i) >> 4, capped at mag_max_i.
- R8: A positive offset never exceeds m_lim_i minus the largest reference. A negative offset never exceeds m_lim_i plus the smallest reference in magnitude. A headroom below zero gives a zero offset. So with all references inside ±m_lim_i, every output stays inside ±m_lim_i.
- R9: The results for the inputs sampled on a strobe edge appear on the outputs directly after that edge. Before that edge the outputs still show the previous result.
- R10: On equal magnitudes, phase A takes precedence over B, and B over C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strobe_i | input | 1 | Control-period update strobe |
| ref_a_i | input | W | Phase A reference, signed |
| ref_b_i | input | W | Phase B reference, signed |
| ref_c_i | input | W | Phase C reference, signed |
| cur_pos_i | input | 3 | Phase current sign, 1 = positive (bit 0 = A) |
| mp_err_i | input | W | Upper minus lower capacitor voltage, signed |
| m_lim_i | input | W-1 | Modulation limit, unsigned |
| gain_i | input | GW | Error gain, 4 fraction bits |
| mag_max_i | input | W-1 | Offset magnitude cap |
| deadband_i | input | W-1 | Error deadband |
| ref_a_o | output | W | Adjusted phase A reference |
| ref_b_o | output | W | Adjusted phase B reference |
| ref_c_o | output | W | Adjusted phase C reference |
| sect_o | output | 3 | Section code |

## Verification
The common-offset and limit properties assume that every sampled reference already lies within ±m_lim_i and that m_lim_i leaves headroom below full scale, so no output saturates. The configuration inputs are assumed to stay constant within a control period. The stimulus uses a limit of 10000 on 16-bit words and keeps every reference inside that limit, including the cases that press against the limit from either side. Polarity is covered for both reference signs of the dominant phase, for both current directions and for both error signs.

// File: rtl/np_zs_pkg.sv
package np_zs_pkg;
  localparam int unsigned NUM_PH = 3;
  localparam int unsigned GAIN_FRAC = 4;

  typedef enum logic [2:0] {
    SECT_A_POS = 3'd0,
    SECT_C_NEG = 3'd1,
    SECT_B_POS = 3'd2,
    SECT_A_NEG = 3'd3,
    SECT_C_POS = 3'd4,
    SECT_B_NEG = 3'd5
  } sect_e;
endpackage

// File: rtl/np_zs_sector.sv
module np_zs_sector
  import np_zs_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic [NUM_PH-1:0][W-1:0] refs_i,
  output logic [1:0]               dom_o,
  output logic                     dom_neg_o,
  output sect_e                    sect_o
);
  logic [NUM_PH-1:0][W:0] mag;

  for (genvar k = 0; k < NUM_PH; k++) begin : g_mag
    assign mag[k] = refs_i[k][W-1] ? ({1'b0, ~refs_i[k]} + (W+1)'(1))
                                   : {1'b0, refs_i[k]};
  end

  logic a_ge_b, a_ge_c, b_ge_c;
  assign a_ge_b = mag[0] >= mag[1];
  assign a_ge_c = mag[0] >= mag[2];
  assign b_ge_c = mag[1] >= mag[2];

  always_comb begin
    if (a_ge_b && a_ge_c) dom_o = 2'd0;
    else if (b_ge_c)      dom_o = 2'd1;
    else                  dom_o = 2'd2;
  end

  always_comb begin
    case (dom_o)
      2'd0:    dom_neg_o = refs_i[0][W-1];
      2'd1:    dom_neg_o = refs_i[1][W-1];
      default: dom_neg_o = refs_i[2][W-1];
    endcase
  end

  always_comb begin
    case ({dom_o, dom_neg_o})
      3'b000:  sect_o = SECT_A_POS;
      3'b001:  sect_o = SECT_A_NEG;
      3'b010:  sect_o = SECT_B_POS;
      3'b011:  sect_o = SECT_B_NEG;
      3'b100:  sect_o = SECT_C_POS;
      default: sect_o = SECT_C_NEG;
    endcase
  end
endmodule

// File: rtl/np_zs_offset.sv
module np_zs_offset
  import np_zs_pkg::*;
#(
  parameter int unsigned W  = 16,
  parameter int unsigned GW = 8
) (
  input  logic signed [W-1:0] err_i,
  input  logic [GW-1:0]       gain_i,
  input  logic [W-2:0]        mag_max_i,
  input  logic [W-2:0]        deadband_i,
  input  logic [W-2:0]        m_lim_i,
  input  logic                sinking_i,
  input  logic signed [W-1:0] ref_max_i,
  input  logic signed [W-1:0] ref_min_i,
  output logic signed [W:0]   offset_o
);
  localparam int unsigned PW = W + GW + 1;

  logic [W:0]    err_abs;
  logic          in_db;
  logic [PW-1:0] prod, scaled;
  logic [W-2:0]  mag;
  logic          pos;

  assign err_abs = err_i[W-1] ? ({1'b0, ~err_i} + (W+1)'(1)) : {1'b0, err_i};
  assign in_db   = err_abs <= {2'b00, deadband_i};
  assign prod    = {{GW{1'b0}}, err_abs} * {{(W+1){1'b0}}, gain_i};
  assign scaled  = prod >> GAIN_FRAC;
  assign mag     = (scaled > {{(GW+2){1'b0}}, mag_max_i}) ? mag_max_i : scaled[W-2:0];
  assign pos     = (~err_i[W-1]) == sinking_i;

  // headroom against the limit in the direction of the offset
  logic signed [W+1:0] lim_ext, head_pos, head_neg, head;
  logic [W-2:0]        amt;

  assign lim_ext  = $signed({3'b000, m_lim_i});
  assign head_pos = lim_ext - {{2{ref_max_i[W-1]}}, ref_max_i};
  assign head_neg = lim_ext + {{2{ref_min_i[W-1]}}, ref_min_i};
  assign head     = pos ? head_pos : head_neg;

  always_comb begin
    if (head[W+1])                              amt = '0;
    else if (head > $signed({3'b000, mag}))     amt = mag;
    else                                        amt = head[W-2:0];
  end

  always_comb begin
    if (in_db)    offset_o = '0;
    else if (pos) offset_o = $signed({2'b00, amt});
    else          offset_o = -$signed({2'b00, amt});
  end
endmodule

// File: rtl/np_zs_sat_add.sv
module np_zs_sat_add #(
  parameter int unsigned W = 16
) (
  input  logic signed [W-1:0] a_i,
  input  logic signed [W:0]   b_i,
  output logic signed [W-1:0] y_o
);
  localparam logic signed [W+1:0] MAX_V = $signed({3'b000, {(W-1){1'b1}}});
  localparam logic signed [W+1:0] MIN_V = -MAX_V - (W+2)'(1);

  logic signed [W+1:0] sum;
  assign sum = {{2{a_i[W-1]}}, a_i} + {b_i[W], b_i};

  always_comb begin
    if (sum > MAX_V)      y_o = MAX_V[W-1:0];
    else if (sum < MIN_V) y_o = MIN_V[W-1:0];
    else                  y_o = sum[W-1:0];
  end
endmodule

// File: rtl/np_zs_balancer.sv
module np_zs_balancer
  import np_zs_pkg::*;
#(
  parameter int unsigned W  = 16,
  parameter int unsigned GW = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                strobe_i,
  input  logic signed [W-1:0] ref_a_i,
  input  logic signed [W-1:0] ref_b_i,
  input  logic signed [W-1:0] ref_c_i,
  input  logic [2:0]          cur_pos_i,
  input  logic signed [W-1:0] mp_err_i,
  input  logic [W-2:0]        m_lim_i,
  input  logic [GW-1:0]       gain_i,
  input  logic [W-2:0]        mag_max_i,
  input  logic [W-2:0]        deadband_i,
  output logic signed [W-1:0] ref_a_o,
  output logic signed [W-1:0] ref_b_o,
  output logic signed [W-1:0] ref_c_o,
  output logic [2:0]          sect_o
);
  logic [NUM_PH-1:0][W-1:0] refs, adj, outs_q;
  assign refs = {ref_c_i, ref_b_i, ref_a_i};

  logic [1:0] dom;
  logic       dom_neg;
  sect_e      sect;

  np_zs_sector #(.W(W)) u_sector (
    .refs_i   (refs),
    .dom_o    (dom),
    .dom_neg_o(dom_neg),
    .sect_o   (sect)
  );

  logic cur_dom, sinking;
  always_comb begin
    case (dom)
      2'd0:    cur_dom = cur_pos_i[0];
      2'd1:    cur_dom = cur_pos_i[1];
      default: cur_dom = cur_pos_i[2];
    endcase
  end
  // P-type vectors drive midpoint current opposite to the dominant phase current
  assign sinking = cur_dom ^ ~dom_neg;

  logic signed [W-1:0] rmax, rmin, mx_ab, mn_ab;
  assign mx_ab = (ref_a_i > ref_b_i) ? ref_a_i : ref_b_i;
  assign mn_ab = (ref_a_i < ref_b_i) ? ref_a_i : ref_b_i;
  assign rmax  = (mx_ab > ref_c_i) ? mx_ab : ref_c_i;
  assign rmin  = (mn_ab < ref_c_i) ? mn_ab : ref_c_i;

  logic signed [W:0] offset;

  np_zs_offset #(.W(W), .GW(GW)) u_offset (
    .err_i     (mp_err_i),
    .gain_i    (gain_i),
    .mag_max_i (mag_max_i),
    .deadband_i(deadband_i),
    .m_lim_i   (m_lim_i),
    .sinking_i (sinking),
    .ref_max_i (rmax),
    .ref_min_i (rmin),
    .offset_o  (offset)
  );

  for (genvar k = 0; k < NUM_PH; k++) begin : g_ph
    np_zs_sat_add #(.W(W)) u_add (
      .a_i(refs[k]),
      .b_i(offset),
      .y_o(adj[k])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       outs_q[k] <= '0;
      else if (strobe_i) outs_q[k] <= adj[k];
    end
  end

  logic [2:0] sect_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sect_q <= '0;
    else if (strobe_i) sect_q <= sect;
  end

  assign ref_a_o = outs_q[0];
  assign ref_b_o = outs_q[1];
  assign ref_c_o = outs_q[2];
  assign sect_o  = sect_q;
endmodule

// File: rtl/np_zs_balancer_chk.sv
module np_zs_balancer_chk #(
  parameter int unsigned W = 16
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                strobe_i,
  input logic signed [W-1:0] ref_a_i,
  input logic signed [W-1:0] ref_b_i,
  input logic signed [W-1:0] ref_c_i,
  input logic signed [W-1:0] mp_err_i,
  input logic [W-2:0]        m_lim_i,
  input logic [W-2:0]        deadband_i,
  input logic signed [W-1:0] ref_a_o,
  input logic signed [W-1:0] ref_b_o,
  input logic signed [W-1:0] ref_c_o,
  input logic [2:0]          sect_o
);
  logic                p_stb;
  logic signed [W+1:0] p_a, p_b, p_c, p_err, p_lim, p_db;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p_stb <= 1'b0; p_a <= '0; p_b <= '0; p_c <= '0;
      p_err <= '0; p_lim <= '0; p_db <= '0;
    end else begin
      p_stb <= strobe_i;
      p_a   <= (W+2)'(ref_a_i);
      p_b   <= (W+2)'(ref_b_i);
      p_c   <= (W+2)'(ref_c_i);
      p_err <= (W+2)'(mp_err_i);
      p_lim <= $signed({3'b000, m_lim_i});
      p_db  <= $signed({3'b000, deadband_i});
    end
  end

  logic signed [W+1:0] oa, ob, oc, abs_err;
  logic                in_rng;
  assign oa      = (W+2)'(ref_a_o);
  assign ob      = (W+2)'(ref_b_o);
  assign oc      = (W+2)'(ref_c_o);
  assign abs_err = p_err[W+1] ? -p_err : p_err;
  assign in_rng  = (p_a <= p_lim) && (p_a >= -p_lim) && (p_b <= p_lim) &&
                   (p_b >= -p_lim) && (p_c <= p_lim) && (p_c >= -p_lim);

  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_i |=> ($stable(ref_a_o) && $stable(ref_b_o) && $stable(ref_c_o) && $stable(sect_o)));

  assert_sect_code_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sect_o <= 3'd5);

  assert_common_offset_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (p_stb && in_rng) |-> ((oa - p_a) == (ob - p_b) && (ob - p_b) == (oc - p_c)));

  assert_deadband_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (p_stb && abs_err <= p_db) |-> (oa == p_a && ob == p_b && oc == p_c));

  assert_limit_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (p_stb && in_rng) |-> (oa <= p_lim && oa >= -p_lim && ob <= p_lim &&
                           ob >= -p_lim && oc <= p_lim && oc >= -p_lim));
endmodule

bind np_zs_balancer np_zs_balancer_chk #(.W(W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .strobe_i  (strobe_i),
  .ref_a_i   (ref_a_i),
  .ref_b_i   (ref_b_i),
  .ref_c_i   (ref_c_i),
  .mp_err_i  (mp_err_i),
  .m_lim_i   (m_lim_i),
  .deadband_i(deadband_i),
  .ref_a_o   (ref_a_o),
  .ref_b_o   (ref_b_o),
  .ref_c_o   (ref_c_o),
  .sect_o    (sect_o)
);

// File: tb/sim_np_zs_balancer.sv
module sim_np_zs_balancer;
  localparam int unsigned W  = 16;
  localparam int unsigned GW = 8;

  logic                clk_i = 1'b0;
  logic                rst_ni = 1'b0;
  logic                strobe_i = 1'b0;
  logic signed [W-1:0] ref_a_i = '0, ref_b_i = '0, ref_c_i = '0, mp_err_i = '0;
  logic [2:0]          cur_pos_i = '0;
  logic [W-2:0]        m_lim_i = 15'd10000, mag_max_i = 15'd2000, deadband_i = 15'd50;
  logic [GW-1:0]       gain_i = 8'd16;
  logic signed [W-1:0] ref_a_o, ref_b_o, ref_c_o;
  logic [2:0]          sect_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  np_zs_balancer #(.W(W), .GW(GW)) u0 (.*);

  task automatic check(string req, int ea, int eb, int ec, int es);
    n_chk++;
    if (ref_a_o !== W'(ea) || ref_b_o !== W'(eb) || ref_c_o !== W'(ec) || sect_o !== 3'(es)) begin
      n_fail++;
      $display("FAIL %s: got a=%0d b=%0d c=%0d s=%0d exp a=%0d b=%0d c=%0d s=%0d",
               req, ref_a_o, ref_b_o, ref_c_o, sect_o, ea, eb, ec, es);
    end
  endtask

  task automatic drive(int a, int b, int c, logic [2:0] cur, int err);
    ref_a_i = W'(a); ref_b_i = W'(b); ref_c_i = W'(c);
    cur_pos_i = cur; mp_err_i = W'(err);
  endtask

  // inputs set at a falling edge, strobe for one cycle, result sampled at the next falling edge
  task automatic update(int a, int b, int c, logic [2:0] cur, int err);
    @(negedge clk_i);
    drive(a, b, c, cur, err);
    strobe_i = 1'b1;
    @(negedge clk_i);
    strobe_i = 1'b0;
  endtask

  task automatic t_reset;
    #1;
    check("R1", 0, 0, 0, 0);
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1", 0, 0, 0, 0);
  endtask

  task automatic t_sections;
    update( 5000, -2500, -2500, 3'b000, 0); check("R3 sect0", 5000, -2500, -2500, 0);
    update( 2500,  2500, -5000, 3'b000, 0); check("R3 sect1", 2500, 2500, -5000, 1);
    update(-2500,  5000, -2500, 3'b000, 0); check("R3 sect2", -2500, 5000, -2500, 2);
    update(-5000,  2500,  2500, 3'b000, 0); check("R3 sect3", -5000, 2500, 2500, 3);
    update(-2500, -2500,  5000, 3'b000, 0); check("R3 sect4", -2500, -2500, 5000, 4);
    update( 2500, -5000,  2500, 3'b000, 0); check("R3 sect5", 2500, -5000, 2500, 5);
  endtask

  task automatic t_polarity;
    update(3000, -1500, -1500, 3'b000,  500); check("R6 R4 sink pos", 3500, -1000, -1000, 0);
    update(3000, -1500, -1500, 3'b000, -500); check("R6 sink neg", 2500, -2000, -2000, 0);
    update(3000, -1500, -1500, 3'b001,  500); check("R6 source pos", 2500, -2000, -2000, 0);
    update(3000, -1500, -1500, 3'b001, -500); check("R6 source neg", 3500, -1000, -1000, 0);
    update(-3000, 1500, 1500, 3'b001,  500); check("R6 neg ref sink", -2500, 2000, 2000, 3);
    update(-3000, 1500, 1500, 3'b000,  500); check("R6 neg ref source", -3500, 1000, 1000, 3);
  endtask

  task automatic t_magnitude;
    update(3000, -1500, -1500, 3'b000, 5000); check("R7 cap", 5000, 500, 500, 0);
    gain_i = 8'd8;
    update(3000, -1500, -1500, 3'b000, 400); check("R7 gain half", 3200, -1300, -1300, 0);
    gain_i = 8'd16;
  endtask

  task automatic t_deadband;
    update(3000, -1500, -1500, 3'b000, 50);  check("R5 edge", 3000, -1500, -1500, 0);
    update(3000, -1500, -1500, 3'b000, -50); check("R5 edge neg", 3000, -1500, -1500, 0);
    update(3000, -1500, -1500, 3'b000, 51);  check("R5 outside", 3051, -1449, -1449, 0);
  endtask

  task automatic t_clamp;
    update( 9800, -4900, -4900, 3'b000, 5000); check("R8 pos", 10000, -4700, -4700, 0);
    update(-9800,  4900,  4900, 3'b000, 5000); check("R8 neg", -10000, 4700, 4700, 3);
    update(10000, -5000, -5000, 3'b000, 5000); check("R8 no room", 10000, -5000, -5000, 0);
  endtask

  task automatic t_ties;
    update( 4000, -4000,     0, 3'b000, 0); check("R10 A over B", 4000, -4000, 0, 0);
    update(    0,  4000, -4000, 3'b000, 0); check("R10 B over C", 0, 4000, -4000, 2);
    update(-4000,     0,  4000, 3'b000, 0); check("R10 A over C", -4000, 0, 4000, 3);
  endtask

  task automatic t_hold_latency;
    update(3000, -1500, -1500, 3'b000, 500);
    @(negedge clk_i);
    drive(-7000, 3500, 3500, 3'b111, -900);
    repeat (3) @(negedge clk_i);
    check("R2 hold", 3500, -1000, -1000, 0);
    drive(0, 6000, -6000, 3'b000, 0);
    strobe_i = 1'b1;
    #1;
    check("R9 before edge", 3500, -1000, -1000, 0);
    @(negedge clk_i);
    strobe_i = 1'b0;
    check("R9 after edge", 0, 6000, -6000, 2);
  endtask

  initial begin
    t_reset();
    t_sections();
    t_polarity();
    t_magnitude();
    t_deadband();
    t_clamp();
    t_ties();
    t_hold_latency();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule